// File: doc/BRIEF.md
# Interval and free-run timer channel

This block is one timer channel behind a small register interface. Software loads a compare value and picks one of two modes, then pulses a start register. In interval mode the counter is loaded from the compare value and counts down. It pulses the interrupt each time it passes zero and reloads, so a compare value of N-1 gives one interrupt every N clocks. In free-run mode the counter clears and counts up across its whole range, wrapping to zero. It pulses the interrupt each time the count equals the compare value.

A separate stop register halts the channel, and the counter keeps its value where it stopped. A read-only enable status shows whether the channel is running, and software polls it after a stop. The compare value and the mode can only be changed while the channel is stopped. Every register is decoded from a byte address, and the 8-bit registers sit in the low byte of the data bus.

Top module: `tmr_channel`

## Requirements
- R1: After reset the compare value, counter, enable status and mode all read 0 (interval mode), and `irq` is low.
- R2: A write to offset 0x14 with data bit 0 set starts the channel. Enable status (offset 0x10, bit 0) then reads 1. The counter loads the compare value in interval mode and clears to 0 in free-run mode.
- R3: A write to offset 0x18 with data bit 0 set stops the channel. Enable status then reads 0, and the counter (offset 0x04) holds its value and stays readable.
- R4: Bit 1 of the control register (offset 0x20) selects the mode: 0 is interval and 1 is free-run. Control reads back only bit 1, and every other bit reads 0.
- R5: In interval mode the counter steps down by one each clock. From 0 it reloads the compare value (offset 0x00). `irq` is high for one clock after each zero, so a compare value of M gives one pulse every M+1 clocks.
- R6: In free-run mode the counter steps up by one each clock and wraps from all-ones to 0.
- R7: In free-run mode `irq` is high for the one clock after the counter equals the compare value, and counting continues after the match.
- R8: `irq` stays low while the channel is stopped, and also in the cycle in which a stop is written.
- R9: Writes to the counter and enable status offsets are ignored. Start and stop writes with data bit 0 clear have no effect. Reads of the start and stop offsets return 0.
- R10: Writes to the compare and control registers are ignored while the channel is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
A counter that loads or reloads the wrong value shows up at once as a wrong count read back at the stop. It also moves every later interrupt by a fixed number of clocks, so counting pulses over a window that spans several periods exposes it within one period. A stale enable state shows on the status read on the cycle after a start or stop is written. It also shows as interrupts, or a missing counter hold, while the channel should be idle. Configuration that leaks through while the channel is running shows when the compare register is read back after the stop.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned OFS_CMP  = 'h00;
   localparam int unsigned OFS_CNT  = 'h04;
   localparam int unsigned OFS_STAT = 'h10;
   localparam int unsigned OFS_GO   = 'h14;
   localparam int unsigned OFS_HALT = 'h18;
   localparam int unsigned OFS_CTRL = 'h20;
   localparam int unsigned BUS_W    = 32;

   typedef enum logic {
      MODE_INTERVAL = 1'b0,
      MODE_FREERUN  = 1'b1
   } tmr_mode_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  cmp_q,
   output tmr_mode_e         mode_q,
   output logic              run_q,
   output logic              go,
   output logic              halt,
   output logic [BUS_W-1:0]  rdata
);
   localparam int PAD_W = BUS_W - CNT_W;

   logic [BUS_W-1:0] cmp_ext, cnt_ext;
   logic             sel_cmp, sel_ctrl;

   assign sel_cmp  = wr_en && (addr == ADDR_W'(OFS_CMP));
   assign sel_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
   assign go       = wr_en && (addr == ADDR_W'(OFS_GO))   && wdata[0];
   assign halt     = wr_en && (addr == ADDR_W'(OFS_HALT)) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cmp_q  <= '0;
         mode_q <= MODE_INTERVAL;
      end else begin
         if (go)
            run_q <= 1'b1;
         else if (halt)
            run_q <= 1'b0;
         if (sel_cmp && !run_q)
            cmp_q <= wdata[CNT_W-1:0];
         if (sel_ctrl && !run_q)
            mode_q <= tmr_mode_e'(wdata[1]);
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign cmp_ext = {{PAD_W{1'b0}}, cmp_q};
         assign cnt_ext = {{PAD_W{1'b0}}, cnt};
      end else begin : g_full
         assign cmp_ext = cmp_q;
         assign cnt_ext = cnt;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFS_CMP))
         rdata = cmp_ext;
      else if (addr == ADDR_W'(OFS_CNT))
         rdata = cnt_ext;
      else if (addr == ADDR_W'(OFS_STAT))
         rdata = {{(BUS_W-1){1'b0}}, run_q};
      else if (addr == ADDR_W'(OFS_CTRL))
         rdata = {{(BUS_W-2){1'b0}}, mode_q, 1'b0};
   end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tmr_mode_e        mode,
   input  logic             run,
   input  logic             go,
   input  logic             halt,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt_q,
   output logic             irq_q
);
   logic tick, hit, at_zero;

   assign tick    = run && !go && !halt;
   assign at_zero = (cnt_q == '0);
   assign hit     = (mode == MODE_FREERUN) ? (cnt_q == cmp) : at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= tick && hit;
         if (go) begin
            cnt_q <= (mode == MODE_FREERUN) ? '0 : cmp;
         end else if (tick) begin
            if (mode == MODE_FREERUN)
               cnt_q <= cnt_q + 1'b1;
            else if (at_zero)
               cnt_q <= cmp;
            else
               cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              irq
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("tmr_channel: CNT_W must lie in 2..32");
      end
      if (ADDR_W < 6) begin : g_bad_addr_w
         $error("tmr_channel: ADDR_W must be at least 6");
      end
   endgenerate

   logic [CNT_W-1:0] cmp_q, cnt_q;
   tmr_mode_e        mode_q;
   logic             run_q, go, halt, irq_q;

   tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .addr   (addr),
      .wdata  (wdata),
      .cnt    (cnt_q),
      .cmp_q  (cmp_q),
      .mode_q (mode_q),
      .run_q  (run_q),
      .go     (go),
      .halt   (halt),
      .rdata  (rdata)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode_q),
      .run   (run_q),
      .go    (go),
      .halt  (halt),
      .cmp   (cmp_q),
      .cnt_q (cnt_q),
      .irq_q (irq_q)
   );

   assign irq = irq_q;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic              run,
   input logic              mode,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cmp,
   input logic              irq
);
   logic go_w, halt_w, cfg_w;
   assign go_w   = wr_en && (addr == ADDR_W'(OFS_GO))   && wdata[0];
   assign halt_w = wr_en && (addr == ADDR_W'(OFS_HALT)) && wdata[0];
   assign cfg_w  = wr_en && (addr == ADDR_W'(OFS_CMP));

   p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      go_w |=> run);

   p_stop_idles_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_w && !go_w) |=> !run);

   p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !go_w) |=> $stable(cnt));

   p_down_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !mode && cnt != '0 && !go_w && !halt_w)
         |=> cnt == CNT_W'($past(cnt) - 1'b1));

   p_up_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode && !go_w && !halt_w)
         |=> cnt == CNT_W'($past(cnt) + 1'b1));

   p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run || halt_w) |=> !irq);

   p_cmp_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cfg_w) |=> $stable(cmp));
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_en (wr_en),
   .addr  (addr),
   .wdata (wdata),
   .run   (run_q),
   .mode  (mode_q),
   .cnt   (cnt_q),
   .cmp   (cmp_q),
   .irq   (irq)
);

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr8 = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, rdata8;
   logic        irq, irq8;
   int          n_vec = 0, n_bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   tmr_channel dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq));

   tmr_channel #(.CNT_W(8)) dut8 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr8), .addr(addr),
      .wdata(wdata), .rdata(rdata8), .irq(irq8));

   // mode, compare, cycles run, expected counter, expected interrupts
   typedef struct packed {
      logic        fr;
      logic [31:0] cmp;
      int          cyc;
      logic [31:0] exp_cnt;
      int          exp_irq;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{1'b0, 32'd4,  12, 32'd2,  2},
      '{1'b0, 32'd0,   6, 32'd0,  6},
      '{1'b0, 32'd9,  25, 32'd4,  2},
      '{1'b1, 32'd5,  10, 32'd10, 1},
      '{1'b1, 32'd0,   3, 32'd3,  1},
      '{1'b1, 32'd20, 15, 32'd15, 0},
      '{1'b0, 32'd1,   7, 32'd0,  3}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // caller sits at a falling edge; write lands on the next rising edge
   task automatic wr(input bit sel, input logic [5:0] a, input logic [31:0] d);
      addr = a; wdata = d;
      if (sel) wr8 = 1'b1; else wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr8 = 1'b0;
   endtask

   task automatic rd(input bit sel, input logic [5:0] a, output logic [31:0] d);
      addr = a;
      #1 d = sel ? rdata8 : rdata;
   endtask

   task automatic run_count(input bit sel, input int cyc, output int pulses);
      pulses = 0;
      for (int k = 1; k <= cyc; k++) begin
         @(negedge clk);
         if ((sel ? irq8 : irq) === 1'b1) pulses++;
      end
   endtask

   initial begin
      logic [31:0] v, v2;
      int p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, 6'h00, v); chk("R1 cmp", v, 0);
      rd(0, 6'h04, v); chk("R1 cnt", v, 0);
      rd(0, 6'h10, v); chk("R1 status", v, 0);
      rd(0, 6'h20, v); chk("R1 ctrl", v, 0);
      chk("R1 irq", {31'b0, irq}, 0);

      // R4 only mode bit kept
      wr(0, 6'h20, 32'hFFFF_FFFF); rd(0, 6'h20, v); chk("R4 ctrl readback", v, 32'h2);
      wr(0, 6'h20, 32'h0);         rd(0, 6'h20, v); chk("R4 ctrl clear", v, 32'h0);

      // R9 ignored writes and trigger reads
      wr(0, 6'h04, 32'h1234); rd(0, 6'h04, v); chk("R9 cnt write ignored", v, 0);
      wr(0, 6'h10, 32'h1);    rd(0, 6'h10, v); chk("R9 status write ignored", v, 0);
      wr(0, 6'h14, 32'hFE);   rd(0, 6'h10, v); chk("R9 start bit0 clear", v, 0);
      rd(0, 6'h14, v); chk("R9 start reads 0", v, 0);
      rd(0, 6'h18, v); chk("R9 stop reads 0", v, 0);

      // vector table: R2 R3 R5 R6 R7
      foreach (VECS[i]) begin
         wr(0, 6'h18, 32'h1);
         wr(0, 6'h20, {30'b0, VECS[i].fr, 1'b0});
         wr(0, 6'h00, VECS[i].cmp);
         wr(0, 6'h14, 32'h1);
         run_count(0, VECS[i].cyc, p);
         wr(0, 6'h18, 32'h1);
         rd(0, 6'h04, v);
         chk(VECS[i].fr ? "R6 count" : "R5 count", v, VECS[i].exp_cnt);
         chk(VECS[i].fr ? "R7 pulses" : "R5 pulses", p, VECS[i].exp_irq);
      end

      // R2 status, R10 config locked while running
      wr(0, 6'h20, 32'h0);
      wr(0, 6'h00, 32'd4);
      wr(0, 6'h14, 32'h1);
      rd(0, 6'h10, v); chk("R2 status set", v, 1);
      wr(0, 6'h00, 32'd99);
      wr(0, 6'h20, 32'h2);
      wr(0, 6'h18, 32'h1);
      rd(0, 6'h00, v); chk("R10 cmp locked", v, 4);
      rd(0, 6'h20, v); chk("R10 ctrl locked", v, 0);

      // R3 stop holds counter, R8 no pulses while idle
      rd(0, 6'h10, v); chk("R3 status clear", v, 0);
      rd(0, 6'h04, v);
      run_count(0, 6, p);
      rd(0, 6'h04, v2); chk("R3 counter held", v2, v);
      chk("R8 idle pulses", p, 0);

      // R6 wrap and R7 match after wrap on the 8-bit channel
      wr(1, 6'h20, 32'h2);
      wr(1, 6'h00, 32'd3);
      wr(1, 6'h14, 32'h1);
      run_count(1, 262, p);
      wr(1, 6'h18, 32'h1);
      rd(1, 6'h04, v); chk("R6 wrap count", v, 6);
      chk("R7 pulses across wrap", p, 2);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule